// File: doc/BRIEF.md
# Constant-Time Binary-Field Scalar Multiplier

This block multiplies an elliptic-curve point by a private scalar over GF(2^M). The curve has the form y^2 + xy = x^3 + ax^2 + b. One engine serves two jobs, and `modeIn` chooses between them. In mode 0 it multiplies the scalar by a fixed base point to form a public key. In mode 1 it multiplies the same scalar by a point whose x coordinate arrives on `pointX`, which yields a shared secret. The scalar is built from two words. The embedded signature word `sigWord` forms the upper bits and the device identifier `devId` forms the lower bits.

The engine works only on x coordinates in projective form and runs a Montgomery ladder over every bit of the scalar, leading zeros included. Every ladder step issues the same sequence of field operations. A conditional register swap before and after each step is the only place where the scalar bit acts. After the ladder, a single Fermat inversion takes the result back to affine x. Multiplication is bit-serial and reduces by a parameterised polynomial. Squaring and addition each complete in one cycle. The default parameters set up a 163-bit field.

A job starts with a one-cycle `startIn`. When the result is ready, `doneOut` pulses once. A public-key result is shown on `resultX` only while `releaseIn` is high.

Top module: `ec_ladder_mult`

## Requirements
- R1: With `modeIn`=0 at start, the result is the affine x of k·G. Here G is the base point given by the parameters, and k = {sigWord, devId}, with sigWord in the most significant bits. `pointX` is ignored in this mode.
- R2: With `modeIn`=1 at start, the result is the affine x of k·Q. Here Q is the curve point whose x coordinate is `pointX`.
- R3: When k·P is the point at infinity (for example k = 0), the result is all zeros.
- R4: A mode-0 result reads as all zeros on `resultX` while `releaseIn` is 0, and reads as its true value while `releaseIn` is 1. A mode-1 result is never masked.
- R5: `doneOut` rises exactly N·(6M+14) + M² + M cycles after the clock edge that accepts `startIn`, where N = SIG_W + DID_W. This count is the same for every scalar and every point.
- R6: `doneOut` is high for exactly one cycle per job.
- R7: A `startIn` that arrives while a job runs is ignored. The running job keeps its result and its timing, and no extra completion follows.
- R8: The scalar, mode and point are captured at the accepting edge. Changes to these inputs during a job have no effect on its result.
- R9: After reset, `doneOut` is 0 and `resultX` is all zeros.
- R10: Between completions, `resultX` changes only when `releaseIn` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Starts a job when the engine is idle |
| modeIn | input | 1 | 0: public key from base point; 1: shared secret from `pointX` |
| sigWord | input | SIG_W | Embedded signature word, upper part of the scalar |
| devId | input | DID_W | Device identifier, lower part of the scalar |
| pointX | input | FIELD_W | x coordinate of the external point (mode 1) |
| releaseIn | input | 1 | Unmasks a public-key result |
| doneOut | output | 1 | One-cycle pulse when the result is valid |
| resultX | output | FIELD_W | Affine x of the product, masked as in R4 |

## Verification
The checks run at an 8-bit field with a pentanomial. Each expected value comes from an affine double-and-add model of the same curve, and the curve's b is derived from a chosen point so that the model and the design agree on the curve. The scalar patterns are 1, 2, zero, all ones and mixed bit patterns. Scalar 1 separates a correct ladder initialisation from a doubling error. Zero exercises the infinity output, and all ones and the mixed patterns expose a swap that is misplaced or inverted. The external points are multiples of the base point, and the placement of sigWord above devId is checked with asymmetric words. The cycle count is compared for every pattern, which shows that no scalar bit changes the timing. Directed runs inject a start and scrambled inputs in the middle of a job.

// File: rtl/ecladder_pkg.sv
package ecladder_pkg;
  localparam int REG_COUNT = 8;
  localparam int REG_IDX_W = $clog2(REG_COUNT);

  // register file roles
  localparam logic [REG_IDX_W-1:0] RX1 = 3'd0;
  localparam logic [REG_IDX_W-1:0] RZ1 = 3'd1;
  localparam logic [REG_IDX_W-1:0] RX2 = 3'd2;
  localparam logic [REG_IDX_W-1:0] RZ2 = 3'd3;
  localparam logic [REG_IDX_W-1:0] RT1 = 3'd4;
  localparam logic [REG_IDX_W-1:0] RT2 = 3'd5;
  localparam logic [REG_IDX_W-1:0] RPX = 3'd6;
  localparam logic [REG_IDX_W-1:0] RCB = 3'd7;

  typedef enum logic [2:0] {
    OP_SWAP, OP_MUL, OP_MAC, OP_SQR, OP_XSQ, OP_COPY
  } fieldOp_e;

  typedef struct packed {
    logic                 load;
    logic                 go;
    fieldOp_e             op;
    logic [REG_IDX_W-1:0] srcA;
    logic [REG_IDX_W-1:0] srcB;
    logic [REG_IDX_W-1:0] dst;
    logic                 swapBit;
    logic                 capture;
  } ladderCtl_t;
endpackage

// File: rtl/ec_ladder_dp.sv
module ec_ladder_dp import ecladder_pkg::*; #(
  parameter int              M        = 163,
  parameter logic [M-1:0]    RED_POLY = 163'hC9,
  parameter logic [M-1:0]    CURVE_B  = 163'h1
) (
  input  logic         clk,
  input  logic         rstN,
  input  ladderCtl_t   ctl,
  input  logic [M-1:0] pointIn,
  output logic         mulLast,
  output logic [M-1:0] xOut
);
  localparam int MC_W = $clog2(M + 1);
  localparam logic [M-1:0] ONE = 1;

  logic [M-1:0] regs [REG_COUNT];
  logic [M-1:0] mulA, mulB, mulAcc, accNext;
  logic [MC_W-1:0] mulCnt;
  logic [REG_IDX_W-1:0] mulDst;
  logic mulMac;

  function automatic logic [M-1:0] xTimes(input logic [M-1:0] v);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? RED_POLY : '0);
  endfunction

  function automatic logic [M-1:0] gfSquare(input logic [M-1:0] v);
    logic [2*M-2:0] wide;
    wide = '0;
    for (int i = 0; i < M; i++) wide[2*i] = v[i];
    for (int i = 2*M-2; i >= M; i--) begin
      if (wide[i]) begin
        wide[i] = 1'b0;
        for (int j = 0; j < M; j++)
          if (RED_POLY[j]) wide[i-M+j] = wide[i-M+j] ^ 1'b1;
      end
    end
    return wide[M-1:0];
  endfunction

  // MSB-first shift-and-add step
  assign accNext = xTimes(mulAcc) ^ (mulB[M-1] ? mulA : '0);
  assign mulLast = (mulCnt == MC_W'(1));
  assign xOut    = regs[RT2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
      mulA <= '0; mulB <= '0; mulAcc <= '0; mulCnt <= '0;
      mulDst <= '0; mulMac <= 1'b0;
    end else begin
      if (ctl.load) begin
        regs[RX1] <= ONE;     regs[RZ1] <= '0;   // infinity
        regs[RX2] <= pointIn; regs[RZ2] <= ONE;  // base point
        regs[RPX] <= pointIn; regs[RCB] <= CURVE_B;
      end
      if (ctl.go) begin
        unique case (ctl.op)
          OP_SWAP: if (ctl.swapBit) begin
            regs[RX1] <= regs[RX2]; regs[RX2] <= regs[RX1];
            regs[RZ1] <= regs[RZ2]; regs[RZ2] <= regs[RZ1];
          end
          OP_MUL, OP_MAC: begin
            mulA   <= regs[ctl.srcA];
            mulB   <= regs[ctl.srcB];
            mulAcc <= '0;
            mulCnt <= MC_W'(M);
            mulDst <= ctl.dst;
            mulMac <= (ctl.op == OP_MAC);
          end
          OP_SQR:  regs[ctl.dst] <= gfSquare(regs[ctl.srcA]);
          OP_XSQ:  regs[ctl.dst] <= gfSquare(regs[ctl.srcA] ^ regs[ctl.srcB]);
          OP_COPY: regs[ctl.dst] <= regs[ctl.srcA];
          default: ;
        endcase
      end
      if (mulCnt != '0) begin
        mulAcc <= accNext;
        mulB   <= mulB << 1;
        mulCnt <= mulCnt - MC_W'(1);
        if (mulLast) regs[mulDst] <= accNext ^ (mulMac ? regs[mulDst] : '0);
      end
    end
  end

  // control must stay silent while the serial multiplier is busy
  AST_NO_ISSUE_IN_MUL: assert property (@(posedge clk) disable iff (!rstN)
    (mulCnt != '0) |-> !ctl.go) else $error("op issued during multiply"); // R5
endmodule

// File: rtl/ec_ladder_ctrl.sv
module ec_ladder_ctrl import ecladder_pkg::*; #(
  parameter int M = 163,
  parameter int N = 163
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic         modeIn,
  input  logic [N-1:0] scalarIn,
  input  logic         mulLast,
  output ladderCtl_t   ctl,
  output logic         modeHeld
);
  localparam int CNT_MAX = (N > M) ? N : M;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam int LATENCY = N * (6 * M + 14) + M * M + M;

  typedef enum logic [1:0] {PH_IDLE, PH_LADDER, PH_INVERT, PH_FINISH} phase_e;

  phase_e phase;
  logic [3:0] step;
  logic [CNT_W-1:0] cnt;
  logic [N-1:0] scalarReg, scalarShift;
  logic waitMul, isMul, advance;
  logic [31:0] busyCnt;
  fieldOp_e opSel;
  logic [REG_IDX_W-1:0] aSel, bSel, dSel;

  assign scalarShift = scalarReg >> cnt;

  always_comb begin
    opSel = OP_SWAP; aSel = RX1; bSel = RX1; dSel = RX1;
    if (phase == PH_LADDER) begin
      unique case (step)
        4'd1:  begin opSel = OP_MUL;  aSel = RX1; bSel = RZ2; dSel = RT1; end
        4'd2:  begin opSel = OP_MUL;  aSel = RX2; bSel = RZ1; dSel = RT2; end
        4'd3:  begin opSel = OP_XSQ;  aSel = RT1; bSel = RT2; dSel = RZ2; end
        4'd4:  begin opSel = OP_MUL;  aSel = RT1; bSel = RT2; dSel = RX2; end
        4'd5:  begin opSel = OP_MAC;  aSel = RPX; bSel = RZ2; dSel = RX2; end
        4'd6:  begin opSel = OP_SQR;  aSel = RX1; dSel = RT1; end
        4'd7:  begin opSel = OP_SQR;  aSel = RZ1; dSel = RT2; end
        4'd8:  begin opSel = OP_MUL;  aSel = RT1; bSel = RT2; dSel = RZ1; end
        4'd9:  begin opSel = OP_SQR;  aSel = RT1; dSel = RT1; end
        4'd10: begin opSel = OP_SQR;  aSel = RT2; dSel = RT2; end
        4'd11: begin opSel = OP_MAC;  aSel = RCB; bSel = RT2; dSel = RT1; end
        4'd12: begin opSel = OP_COPY; aSel = RT1; dSel = RX1; end
        default: opSel = OP_SWAP;  // steps 0 and 13
      endcase
    end else if (phase == PH_INVERT) begin
      unique case (step)
        4'd0:    begin opSel = OP_COPY; aSel = RZ1; dSel = RT1; end
        4'd2:    begin opSel = OP_MUL;  aSel = RT1; bSel = RZ1; dSel = RT1; end
        4'd4:    begin opSel = OP_MUL;  aSel = RX1; bSel = RT1; dSel = RT2; end
        default: begin opSel = OP_SQR;  aSel = RT1; dSel = RT1; end
      endcase
    end
    isMul       = (opSel == OP_MUL) || (opSel == OP_MAC);
    ctl.load    = (phase == PH_IDLE) && startIn;
    ctl.go      = ((phase == PH_LADDER) || (phase == PH_INVERT)) && !waitMul;
    ctl.op      = opSel;
    ctl.srcA    = aSel;
    ctl.srcB    = bSel;
    ctl.dst     = dSel;
    ctl.swapBit = scalarShift[0];
    ctl.capture = (phase == PH_FINISH);
    advance     = (ctl.go && !isMul) || mulLast;
  end

  assign modeHeld = 1'b0 ^ modeReg;
  logic modeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE; step <= '0; cnt <= '0; waitMul <= 1'b0;
      scalarReg <= '0; modeReg <= 1'b0; busyCnt <= '0;
    end else begin
      if (phase != PH_IDLE) busyCnt <= busyCnt + 32'd1;
      if (ctl.go && isMul) waitMul <= 1'b1;
      if (mulLast)         waitMul <= 1'b0;
      if (ctl.load) begin
        scalarReg <= scalarIn; modeReg <= modeIn;
        phase <= PH_LADDER; step <= '0; cnt <= CNT_W'(N - 1); busyCnt <= '0;
      end else if (phase == PH_FINISH) begin
        phase <= PH_IDLE;
      end else if (advance) begin
        if (phase == PH_LADDER) begin
          if (step == 4'd13) begin
            step <= '0;
            if (cnt == '0) begin phase <= PH_INVERT; cnt <= CNT_W'(M - 2); end
            else cnt <= cnt - CNT_W'(1);
          end else step <= step + 4'd1;
        end else begin
          if (step == 4'd2) begin
            if (cnt == CNT_W'(1)) step <= 4'd3;
            else begin cnt <= cnt - CNT_W'(1); step <= 4'd1; end
          end else if (step == 4'd4) phase <= PH_FINISH;
          else step <= step + 4'd1;
        end
      end
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_FINISH) |-> (busyCnt == 32'(LATENCY - 1))) else $error("latency drift"); // R5
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE) |=> ($stable(scalarReg) && $stable(modeReg))) else $error("operands moved"); // R7
endmodule

// File: rtl/ec_ladder_mult.sv
module ec_ladder_mult import ecladder_pkg::*; #(
  parameter int                FIELD_W  = 163,
  parameter logic [FIELD_W-1:0] RED_POLY = 163'hC9,
  parameter int                SIG_W    = 115,
  parameter int                DID_W    = 48,
  parameter logic [FIELD_W-1:0] BASE_X   = 163'h3F0EBA16286A2D57EA0991168D4994637E8343E36,
  parameter logic [FIELD_W-1:0] CURVE_B  = 163'h20A601907B8C953CA1481EB10512F78744A3205FD
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  input  logic               modeIn,
  input  logic [SIG_W-1:0]   sigWord,
  input  logic [DID_W-1:0]   devId,
  input  logic [FIELD_W-1:0] pointX,
  input  logic               releaseIn,
  output logic               doneOut,
  output logic [FIELD_W-1:0] resultX
);
  localparam int SCALAR_W = SIG_W + DID_W;

  ladderCtl_t ctl;
  logic mulLast, modeHeld, resMode;
  logic [FIELD_W-1:0] dpX, resReg, pointSel;

  assign pointSel = modeIn ? pointX : BASE_X;

  ec_ladder_ctrl #(.M(FIELD_W), .N(SCALAR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .modeIn(modeIn),
    .scalarIn({sigWord, devId}), .mulLast(mulLast), .ctl(ctl), .modeHeld(modeHeld)
  );

  ec_ladder_dp #(.M(FIELD_W), .RED_POLY(RED_POLY), .CURVE_B(CURVE_B)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pointIn(pointSel),
    .mulLast(mulLast), .xOut(dpX)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resReg <= '0; resMode <= 1'b0; doneOut <= 1'b0;
    end else begin
      doneOut <= ctl.capture;
      if (ctl.capture) begin
        resReg  <= dpX;
        resMode <= modeHeld;
      end
    end
  end

  assign resultX = (resMode || releaseIn) ? resReg : '0;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut) else $error("done longer than one cycle"); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!doneOut && $stable(releaseIn)) |-> $stable(resultX)) else $error("result moved"); // R10
endmodule

// File: tb/ec_ladder_mult_tb.sv
module ec_ladder_mult_tb;
  localparam int M = 8;
  localparam int SW = 5;
  localparam int DW = 3;
  localparam int N = SW + DW;
  localparam logic [M-1:0] POLY = 8'h1B;  // x^8+x^4+x^3+x+1
  localparam logic [M-1:0] ACO = 8'h01;
  localparam logic [M-1:0] GX = 8'h53;
  localparam logic [M-1:0] GY = 8'hCA;
  localparam int LAT_EXP = N * (6 * M + 14) + M * M + M;

  typedef struct packed { logic inf; logic [M-1:0] x; logic [M-1:0] y; } pt_t;
  typedef struct packed { logic md; logic [SW-1:0] sg; logic [DW-1:0] dd; logic [7:0] qm; } vec_t;

  function automatic logic [M-1:0] gfMul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r;
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = {r[M-2:0], 1'b0} ^ (r[M-1] ? POLY : '0);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [M-1:0] gfInv(input logic [M-1:0] a);
    logic [M-1:0] r;
    r = 1;
    for (int i = 0; i < (1 << M) - 2; i++) r = gfMul(r, a);
    return r;
  endfunction

  function automatic logic [M-1:0] curveBOf(input logic [M-1:0] x, input logic [M-1:0] y);
    return gfMul(y, y) ^ gfMul(x, y) ^ gfMul(gfMul(x, x), x) ^ gfMul(ACO, gfMul(x, x));
  endfunction

  localparam logic [M-1:0] CB = curveBOf(GX, GY);

  function automatic pt_t ptDbl(input pt_t p);
    pt_t r;
    logic [M-1:0] lam;
    r = '0;
    if (p.inf || p.x == '0) begin r.inf = 1'b1; return r; end
    lam = p.x ^ gfMul(p.y, gfInv(p.x));
    r.x = gfMul(lam, lam) ^ lam ^ ACO;
    r.y = gfMul(p.x, p.x) ^ gfMul(lam ^ 8'h01, r.x);
    return r;
  endfunction

  function automatic pt_t ptAdd(input pt_t p, input pt_t q);
    pt_t r;
    logic [M-1:0] lam;
    r = '0;
    if (p.inf) return q;
    if (q.inf) return p;
    if (p.x == q.x) begin
      if (p.y == q.y) return ptDbl(p);
      r.inf = 1'b1; return r;
    end
    lam = gfMul(p.y ^ q.y, gfInv(p.x ^ q.x));
    r.x = gfMul(lam, lam) ^ lam ^ p.x ^ q.x ^ ACO;
    r.y = gfMul(lam, p.x ^ r.x) ^ r.x ^ p.y;
    return r;
  endfunction

  function automatic pt_t ptMul(input logic [7:0] k, input pt_t p);
    pt_t r;
    r = '0; r.inf = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      r = ptDbl(r);
      if (k[i]) r = ptAdd(r, p);
    end
    return r;
  endfunction

  function automatic logic [M-1:0] xOf(input pt_t p);
    return p.inf ? '0 : p.x;
  endfunction

  localparam vec_t VECS [8] = '{
    '{1'b0, 5'd0,  3'd1, 8'd1},   // k=1
    '{1'b0, 5'd0,  3'd2, 8'd1},   // k=2
    '{1'b0, 5'd0,  3'd0, 8'd1},   // k=0 -> infinity
    '{1'b0, 5'd31, 3'd7, 8'd1},   // all ones
    '{1'b0, 5'd20, 3'd5, 8'd1},   // 0xA5
    '{1'b1, 5'd0,  3'd7, 8'd3},   // k=7, Q=3G
    '{1'b1, 5'd11, 3'd2, 8'd5},   // 0x5A, Q=5G
    '{1'b1, 5'd16, 3'd0, 8'd2}    // 0x80, Q=2G
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0, modeIn = 1'b0, releaseIn = 1'b0;
  logic [SW-1:0] sigWord = '0;
  logic [DW-1:0] devId = '0;
  logic [M-1:0] pointX = '0;
  logic doneOut;
  logic [M-1:0] resultX;
  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  ec_ladder_mult #(.FIELD_W(M), .RED_POLY(POLY), .SIG_W(SW), .DID_W(DW),
                   .BASE_X(GX), .CURVE_B(CB)) u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .modeIn(modeIn), .sigWord(sigWord),
    .devId(devId), .pointX(pointX), .releaseIn(releaseIn), .doneOut(doneOut), .resultX(resultX)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // kind 1: scramble inputs at cycle `at`; kind 2: also pulse start
  task automatic runJob(input logic md, input logic [SW-1:0] sg, input logic [DW-1:0] dd,
                        input logic [M-1:0] px, input int at, input int kind, output int lat);
    @(negedge clk);
    modeIn = md; sigWord = sg; devId = dd; pointX = px; startIn = 1'b1;
    @(posedge clk);
    #1 startIn = 1'b0;
    lat = 0;
    while (lat < 3000) begin
      @(posedge clk);
      lat++;
      #1;
      startIn = 1'b0;
      if (doneOut) break;
      if (kind != 0 && lat == at) begin
        sigWord = ~sg; devId = ~dd; pointX = px ^ 8'h3C; modeIn = ~md;
        if (kind == 2) startIn = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    int lat;
    int quiet;
    pt_t g, q;
    logic [M-1:0] expX, held;
    g = '{1'b0, GX, GY};
    repeat (3) @(posedge clk);
    #1;
    check("R9", "done after reset", 32'(doneOut), 32'd0);
    check("R9", "result after reset", 32'(resultX), 32'd0);
    rstN = 1'b1;
    @(posedge clk); #1;
    releaseIn = 1'b1; #1;
    check("R9", "result after reset, released", 32'(resultX), 32'd0);
    releaseIn = 1'b0;

    for (int i = 0; i < 8; i++) begin
      q = ptMul(VECS[i].qm, g);
      expX = xOf(ptMul({VECS[i].sg, VECS[i].dd}, VECS[i].md ? q : g));
      runJob(VECS[i].md, VECS[i].sg, VECS[i].dd, VECS[i].md ? q.x : 8'hEE, 0, 0, lat);
      check("R5", $sformatf("latency vec %0d", i), 32'(lat), 32'(LAT_EXP));
      if (!VECS[i].md) begin
        check("R4", $sformatf("masked vec %0d", i), 32'(resultX), 32'd0);
        releaseIn = 1'b1; #1;
        check(expX == '0 ? "R3" : "R1", $sformatf("keygen vec %0d", i), 32'(resultX), 32'(expX));
        releaseIn = 1'b0;
      end else begin
        check("R2", $sformatf("shared vec %0d (R4 unmasked)", i), 32'(resultX), 32'(expX));
      end
      @(posedge clk); #1;
      check("R6", $sformatf("done pulse vec %0d", i), 32'(doneOut), 32'd0);
    end

    // R7: start while busy
    expX = xOf(ptMul(8'hA5, g));
    runJob(1'b0, 5'd20, 3'd5, 8'h00, 100, 2, lat);
    check("R7", "latency with busy start", 32'(lat), 32'(LAT_EXP));
    releaseIn = 1'b1; #1;
    check("R7", "result with busy start", 32'(resultX), 32'(expX));
    releaseIn = 1'b0;
    quiet = 0;
    for (int c = 0; c < LAT_EXP + 20; c++) begin
      @(posedge clk); #1;
      if (doneOut) quiet++;
    end
    check("R7", "no extra completion", 32'(quiet), 32'd0);

    // R8: inputs scrambled mid-job
    expX = xOf(ptMul(8'h3C, g));
    runJob(1'b1, 5'd7, 3'd4, GX, 5, 1, lat);
    check("R8", "result with scrambled inputs", 32'(resultX), 32'(expX));
    check("R5", "latency with scrambled inputs", 32'(lat), 32'(LAT_EXP));

    // R10: result held while inputs wander
    held = resultX;
    sigWord = 5'd9; devId = 3'd3; pointX = 8'h77; modeIn = 1'b0;
    repeat (40) @(posedge clk);
    #1;
    check("R10", "result held", 32'(resultX), 32'(held));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule